// File: doc/BRIEF.md
# Threshold-Gated Interrupt Priority Selector

This block picks one interrupt for a single target context of a platform interrupt controller. Three bit vectors are presented as 32-bit words: sources waiting for service, sources a handler has already taken and not yet finished, and sources this context accepts. A source is a candidate only when it is waiting, not taken, and accepted. The context also has a threshold. A candidate must have a priority strictly above that threshold to be chosen. The block then returns the number of the winning source.

Among candidates, the highest priority wins. When priorities tie, the lowest source number wins. The value zero means "nothing to service". Source zero is reserved and can never be chosen. A level-sensitive request line is high exactly when the returned number is nonzero. The winner and the request line are registered, so they follow the inputs sampled at the previous rising clock edge.

Top module: `ctx_irq_sel`

## Requirements
- R1: Source k (k ≥ 1) is a candidate only when bit k of `pend_i` is 1, bit k of `claimed_i` is 0 and bit k of `enable_i` is 1. When there is no candidate, `id_o` is 0.
- R2: A candidate is chosen only when its priority is strictly greater than `thresh_i`. A priority equal to the threshold does not qualify.
- R3: Among qualifying candidates, `id_o` is the source with the largest priority. The priority of source k sits at `prio_i[k*PRIO_BITS +: PRIO_BITS]`, unsigned.
- R4: When several qualifying candidates share the largest priority, the one with the lowest source number is chosen.
- R5: `irq_o` is 1 exactly when `id_o` is nonzero.
- R6: Bits of the word vectors at positions NUM_SOURCES and above are ignored, and `id_o` is always below NUM_SOURCES.
- R7: Bit 0 (source 0) never causes a nonzero `id_o`, whatever its priority.
- R8: `id_o` and `irq_o` reflect the inputs sampled at the previous rising edge of `clk_i`: one cycle of latency.
- R9: While `rst_ni` is low, `id_o` and `irq_o` are 0, and they clear without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 32*ceil(NUM_SOURCES/32) | Waiting sources, bit k = source k |
| claimed_i | input | 32*ceil(NUM_SOURCES/32) | Sources in service, bit k = source k |
| enable_i | input | 32*ceil(NUM_SOURCES/32) | Sources accepted by this context |
| prio_i | input | NUM_SOURCES*PRIO_BITS | Per-source priority, source k at k*PRIO_BITS |
| thresh_i | input | PRIO_BITS | Context threshold |
| id_o | output | clog2(NUM_SOURCES) | Winning source, 0 when none |
| irq_o | output | 1 | Request to the target, high when id_o is nonzero |

## Verification
Masking and ranking act in the same cycle. A source can hold the top priority and still be masked, because it is taken or not accepted. The selector must then fall back to the best remaining candidate, and a tie between survivors must still resolve to the lowest number. The bench provokes this with vectors where the overall maximum is claimed or disabled while two lower sources share a priority. It also pairs a threshold equal to a candidate's priority with a second candidate just above it. Each such case is judged against a reference scan computed in the bench, both in fixed vectors and over randomized inputs.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int WORD_W = 32;

  function automatic int words_for(input int n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction

  // index width for n entries, at least one bit
  function automatic int idx_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction
endpackage

// File: rtl/irq_elig_mask.sv
module irq_elig_mask #(
  parameter int NUM_SOURCES = 32,
  parameter int VEC_W       = 32
) (
  input  logic [VEC_W-1:0]       pend_i,
  input  logic [VEC_W-1:0]       claimed_i,
  input  logic [VEC_W-1:0]       enable_i,
  output logic [NUM_SOURCES-1:0] elig_o
);
  // source 0 is reserved: never a candidate
  assign elig_o[0] = 1'b0;

  for (genvar k = 1; k < NUM_SOURCES; k++) begin : g_bit
    assign elig_o[k] = pend_i[k] & ~claimed_i[k] & enable_i[k];
  end

  // bits past the last source and bit 0 carry nothing
  if (VEC_W > NUM_SOURCES) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^{pend_i[VEC_W-1:NUM_SOURCES], claimed_i[VEC_W-1:NUM_SOURCES],
                          enable_i[VEC_W-1:NUM_SOURCES], pend_i[0], claimed_i[0], enable_i[0]};
  end else begin : g_nopad
    logic unused_b0;
    assign unused_b0 = ^{pend_i[0], claimed_i[0], enable_i[0]};
  end
endmodule

// File: rtl/irq_cmp_node.sv
module irq_cmp_node #(
  parameter int PRIO_BITS = 3,
  parameter int ID_W      = 5
) (
  input  logic                 lo_v_i,
  input  logic [PRIO_BITS-1:0] lo_p_i,
  input  logic [ID_W-1:0]      lo_id_i,
  input  logic                 hi_v_i,
  input  logic [PRIO_BITS-1:0] hi_p_i,
  input  logic [ID_W-1:0]      hi_id_i,
  output logic                 v_o,
  output logic [PRIO_BITS-1:0] p_o,
  output logic [ID_W-1:0]      id_o
);
  logic take_hi;

  // the upper-numbered side wins only on a strictly larger priority
  assign take_hi = hi_v_i & (~lo_v_i | (hi_p_i > lo_p_i));

  assign v_o  = lo_v_i | hi_v_i;
  assign p_o  = take_hi ? hi_p_i  : lo_p_i;
  assign id_o = take_hi ? hi_id_i : lo_id_i;
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_sel_pkg::*;
#(
  parameter int NUM_SOURCES = 32,
  parameter int PRIO_BITS   = 3,
  parameter int ID_W        = idx_bits(NUM_SOURCES)
) (
  input  logic [NUM_SOURCES-1:0]           elig_i,
  input  logic [NUM_SOURCES*PRIO_BITS-1:0] prio_i,
  input  logic [PRIO_BITS-1:0]             thresh_i,
  output logic                             v_o,
  output logic [ID_W-1:0]                  id_o
);
  localparam int LEAVES = 1 << ID_W;
  localparam int NODES  = 2 * LEAVES - 1;

  // heap layout: node n has children 2n+1 (lower ids) and 2n+2
  logic                 nd_v  [NODES];
  logic [PRIO_BITS-1:0] nd_p  [NODES];
  logic [ID_W-1:0]      nd_id [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NUM_SOURCES) begin : g_real
      logic [PRIO_BITS-1:0] p;
      assign p                     = prio_i[k*PRIO_BITS +: PRIO_BITS];
      assign nd_v [LEAVES-1+k]     = elig_i[k] & (p > thresh_i);
      assign nd_p [LEAVES-1+k]     = p;
      assign nd_id[LEAVES-1+k]     = ID_W'(k);
    end else begin : g_pad
      assign nd_v [LEAVES-1+k]     = 1'b0;
      assign nd_p [LEAVES-1+k]     = '0;
      assign nd_id[LEAVES-1+k]     = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    irq_cmp_node #(
      .PRIO_BITS (PRIO_BITS),
      .ID_W      (ID_W)
    ) u_node (
      .lo_v_i  (nd_v [2*n+1]),
      .lo_p_i  (nd_p [2*n+1]),
      .lo_id_i (nd_id[2*n+1]),
      .hi_v_i  (nd_v [2*n+2]),
      .hi_p_i  (nd_p [2*n+2]),
      .hi_id_i (nd_id[2*n+2]),
      .v_o     (nd_v [n]),
      .p_o     (nd_p [n]),
      .id_o    (nd_id[n])
    );
  end

  logic [PRIO_BITS-1:0] unused_root_p;
  assign unused_root_p = nd_p[0];

  assign v_o  = nd_v[0];
  assign id_o = nd_id[0];
endmodule

// File: rtl/ctx_irq_sel.sv
module ctx_irq_sel
  import irq_sel_pkg::*;
#(
  parameter int NUM_SOURCES = 32,
  parameter int PRIO_BITS   = 3,
  localparam int VEC_W      = WORD_W * words_for(NUM_SOURCES),
  localparam int ID_W       = idx_bits(NUM_SOURCES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [VEC_W-1:0]                 pend_i,
  input  logic [VEC_W-1:0]                 claimed_i,
  input  logic [VEC_W-1:0]                 enable_i,
  input  logic [NUM_SOURCES*PRIO_BITS-1:0] prio_i,
  input  logic [PRIO_BITS-1:0]             thresh_i,
  output logic [ID_W-1:0]                  id_o,
  output logic                             irq_o
);
  logic [NUM_SOURCES-1:0] elig;
  logic                   win_v;
  logic [ID_W-1:0]        win_id;

  irq_elig_mask #(
    .NUM_SOURCES (NUM_SOURCES),
    .VEC_W       (VEC_W)
  ) u_mask (
    .pend_i    (pend_i),
    .claimed_i (claimed_i),
    .enable_i  (enable_i),
    .elig_o    (elig)
  );

  irq_prio_tree #(
    .NUM_SOURCES (NUM_SOURCES),
    .PRIO_BITS   (PRIO_BITS),
    .ID_W        (ID_W)
  ) u_tree (
    .elig_i   (elig),
    .prio_i   (prio_i),
    .thresh_i (thresh_i),
    .v_o      (win_v),
    .id_o     (win_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o  <= '0;
      irq_o <= 1'b0;
    end else begin
      id_o  <= win_v ? win_id : '0;
      irq_o <= win_v;
    end
  end
endmodule

// File: rtl/ctx_irq_sel_chk.sv
module ctx_irq_sel_chk #(
  parameter int NUM_SOURCES = 32,
  parameter int PRIO_BITS   = 3,
  parameter int VEC_W       = 32,
  parameter int ID_W        = 5
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [VEC_W-1:0]                 pend_i,
  input logic [VEC_W-1:0]                 claimed_i,
  input logic [VEC_W-1:0]                 enable_i,
  input logic [NUM_SOURCES*PRIO_BITS-1:0] prio_i,
  input logic [PRIO_BITS-1:0]             thresh_i,
  input logic [ID_W-1:0]                  id_o,
  input logic                             irq_o
);
  logic                             armed_q;
  logic [VEC_W-1:0]                 cand_q;
  logic [NUM_SOURCES*PRIO_BITS-1:0] prio_q;
  logic [PRIO_BITS-1:0]             thr_q;
  logic [PRIO_BITS-1:0]             sel_p;
  logic                             sel_cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cand_q  <= '0;
      prio_q  <= '0;
      thr_q   <= '0;
    end else begin
      armed_q <= 1'b1;
      cand_q  <= pend_i & ~claimed_i & enable_i;
      prio_q  <= prio_i;
      thr_q   <= thresh_i;
    end
  end

  always_comb begin
    sel_p    = '0;
    sel_cand = 1'b0;
    for (int k = 0; k < NUM_SOURCES; k++) begin
      if (id_o == ID_W'(k)) begin
        sel_p    = prio_q[k*PRIO_BITS +: PRIO_BITS];
        sel_cand = cand_q[k];
      end
    end
  end

  p_chosen_is_candidate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && id_o != '0) |-> sel_cand);

  p_none_gives_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cand_q[NUM_SOURCES-1:1] == '0) |-> id_o == '0);

  p_above_threshold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && id_o != '0) |-> sel_p > thr_q);

  p_request_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (id_o != '0));

  p_id_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(id_o) < NUM_SOURCES);
endmodule

bind ctx_irq_sel ctx_irq_sel_chk #(
  .NUM_SOURCES (NUM_SOURCES),
  .PRIO_BITS   (PRIO_BITS),
  .VEC_W       (VEC_W),
  .ID_W        (ID_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pend_i    (pend_i),
  .claimed_i (claimed_i),
  .enable_i  (enable_i),
  .prio_i    (prio_i),
  .thresh_i  (thresh_i),
  .id_o      (id_o),
  .irq_o     (irq_o)
);

// File: tb/ctx_irq_sel_tb.sv
`timescale 1ns/1ps
module ctx_irq_sel_tb;
  localparam int NS = 40;
  localparam int PB = 3;
  localparam int VW = 64;
  localparam int IW = 6;

  typedef struct packed {
    logic [63:0] pend;
    logic [63:0] claim;
    logic [63:0] en;
    logic [2:0]  thr;
    logic [5:0]  exp;
  } vec_t;

  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;
  // source priorities: source 0 -> 7, others k % 8
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{64'h28,                   64'h0,  ALL,                    3'd0, 6'd5},  // R3
    '{64'h8080,                 64'h0,  ALL,                    3'd0, 6'd7},  // R4
    '{64'h8080,                 64'h80, ALL,                    3'd0, 6'd15}, // R1 claimed
    '{64'h8080,                 64'h0,  64'hFFFF_FFFF_FFFF_7FFF, 3'd0, 6'd7},  // R1 disabled
    '{64'h20,                   64'h0,  ALL,                    3'd5, 6'd0},  // R2 equal
    '{64'h20,                   64'h0,  ALL,                    3'd4, 6'd5},  // R2 above
    '{64'hFFFF_FF00_0000_1000,  64'h0,  ALL,                    3'd0, 6'd12}, // R6
    '{64'h5,                    64'h0,  ALL,                    3'd0, 6'd2},  // R7
    '{64'h0,                    64'h0,  ALL,                    3'd0, 6'd0},  // R5
    '{64'h0000_0080_8000_0200,  64'h0,  ALL,                    3'd0, 6'd31}, // R4 word edge
    '{64'h2_0202,               64'h0,  ALL,                    3'd0, 6'd1},  // R4 low tie
    '{ALL,                      64'h0,  ALL,                    3'd7, 6'd0}   // R2 top
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [VW-1:0]     pend, claim, en;
  logic [NS*PB-1:0]  prio;
  logic [PB-1:0]     thr;
  logic [IW-1:0]     id;
  logic              irq;
  int                n_tests = 0;
  int                n_fail  = 0;

  always #2.5 clk = ~clk;

  ctx_irq_sel #(.NUM_SOURCES(NS), .PRIO_BITS(PB)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pend_i    (pend),
    .claimed_i (claim),
    .enable_i  (en),
    .prio_i    (prio),
    .thresh_i  (thr),
    .id_o      (id),
    .irq_o     (irq)
  );

  function automatic string tag_of(input int i);
    case (i)
      0: return "R3";
      1, 9, 10: return "R4";
      2, 3: return "R1";
      4, 5, 11: return "R2";
      6: return "R6";
      7: return "R7";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [IW-1:0] ref_pick();
    int best_p = int'(thr);
    int best_k = 0;
    for (int k = 1; k < NS; k++) begin
      int p = int'(prio[k*PB +: PB]);
      if (pend[k] && !claim[k] && en[k] && p > best_p) begin
        best_p = p;
        best_k = k;
      end
    end
    return IW'(best_k);
  endfunction

  task automatic chk(input string tag, input logic [IW-1:0] exp);
    n_tests++;
    if (id !== exp || irq !== (exp != '0)) begin
      n_fail++;
      $display("FAIL %s id=%0d irq=%0b expected id=%0d irq=%0b", tag, id, irq, exp, exp != '0);
    end
  endtask

  task automatic apply(input logic [63:0] p, input logic [63:0] c, input logic [63:0] e,
                       input logic [2:0] t);
    @(negedge clk);
    pend = p; claim = c; en = e; thr = t;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int k = 0; k < NS; k++) prio[k*PB +: PB] = (k == 0) ? 3'd7 : PB'(k % 8);
    pend = ALL; claim = '0; en = ALL; thr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", '0);  // would-be winner held off by reset
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].pend, TBL[i].claim, TBL[i].en, TBL[i].thr);
      chk(tag_of(i), TBL[i].exp);
    end

    // R6: only bits past the last source set
    apply(64'hFFFF_FF00_0000_0000, 64'h0, ALL, 3'd0);
    chk("R6", '0);
    // R7: only source 0, top priority
    apply(64'h1, 64'h0, ALL, 3'd0);
    chk("R7", '0);
    // R1 + R4: top source claimed, two survivors tie
    apply(64'h0000_0000_0080_0202, 64'h0080_0000, ALL, 3'd0);
    chk("R1", 6'd1);

    // R8: output holds until the next edge
    apply(64'h28, 64'h0, ALL, 3'd0);
    @(negedge clk);
    pend = 64'h8080;
    #1;
    chk("R8", 6'd5);
    @(posedge clk);
    #1;
    chk("R8", 6'd7);

    // R9: asynchronous clear mid-run
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R9", '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 random against reference scan
    for (int n = 0; n < 400; n++) begin
      logic [63:0] rp, rc, re;
      rp = {$urandom, $urandom};
      rc = {$urandom, $urandom} & {$urandom, $urandom};
      re = {$urandom, $urandom} | {$urandom, $urandom};
      for (int k = 0; k < NS; k++) prio[k*PB +: PB] = PB'($urandom);
      @(negedge clk);
      pend = rp; claim = rc; en = re; thr = PB'($urandom);
      @(posedge clk);
      #1;
      chk("R3", ref_pick());
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule